// File: doc/BRIEF.md
# Display-Mode Gated Video Memory Access Controller

This block stands between a processor bus and the two memories a display controller reads while it draws: a pattern (tile) RAM and a small sprite attribute RAM. The display controller reports its current phase as a 2-bit mode, plus a flag that says whether the display is running. From these the block decides, access by access, whether the processor may touch each memory. A refused write never reaches the RAM. A refused read returns all ones, with the same one-cycle latency as a served read, so the processor never stalls.

The sprite RAM has three possible users: a bulk-copy DMA engine, the display's sprite fetcher and the processor. The block grants the single RAM port to one of them per cycle, with DMA first, then the fetcher, then the processor. A fetcher read that loses to DMA returns all ones. Both RAMs are external single-port synchronous memories with one cycle of read latency.

Top module: `vidmem_gate`

## Requirements
- R1: With the display on and mode 00 (horizontal blank) or 01 (vertical blank), processor reads and writes reach both memories. The pattern window is 0x8000–0x9FFF and the sprite window is 0xFE00–0xFE9F.
- R2: In mode 10 (object search), the pattern RAM stays readable and writable. Processor writes to the sprite RAM are dropped, and reads of it return 0xFF.
- R3: In mode 11 (pixel transfer), processor writes to either memory are dropped, the stored data is left unchanged, and reads of either memory return 0xFF.
- R4: While the display is off, both memories are accessible whatever the mode bits say.
- R5: The access decision uses the mode and display flag registered at the previous clock edge. An access presented in the same cycle as a mode change is therefore judged by the old mode.
- R6: While the DMA request is high, the sprite RAM is written at the DMA address with the DMA data, and processor accesses to the sprite RAM are refused in every mode (write dropped, read 0xFF).
- R7: A fetcher read returns the stored sprite byte one cycle later when DMA is idle, and 0xFF when DMA was active in the request cycle.
- R8: Processor read data appears exactly one cycle after the request. An address outside both windows reads 0xFF and writes nothing.
- R9: During reset no memory enable is asserted, and both read-data outputs show 0xFF.
- R10: When the fetcher and the processor both request the sprite RAM in the same cycle, the fetcher is served and the processor's read returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | Processor byte address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rd | input | 1 | Processor read strobe, one cycle per access |
| cpu_wr | input | 1 | Processor write strobe; wins over cpu_rd |
| cpu_rdata | output | 8 | Read data, one cycle after cpu_rd |
| lcd_mode | input | 2 | Display phase: 00 hblank, 01 vblank, 10 search, 11 transfer |
| lcd_on | input | 1 | Display running |
| dma_active | input | 1 | DMA engine writes the sprite RAM this cycle |
| dma_addr | input | 8 | Sprite RAM byte index for the DMA write |
| dma_wdata | input | 8 | DMA write data |
| fetch_rd | input | 1 | Sprite fetcher read request |
| fetch_addr | input | 8 | Sprite RAM byte index for the fetcher |
| fetch_rdata | output | 8 | Fetcher read data, one cycle after fetch_rd |
| pat_en | output | 1 | Pattern RAM enable |
| pat_we | output | 1 | Pattern RAM write enable |
| pat_addr | output | 13 | Pattern RAM address |
| pat_wdata | output | 8 | Pattern RAM write data |
| pat_rdata | input | 8 | Pattern RAM read data (one-cycle latency) |
| spr_en | output | 1 | Sprite RAM enable |
| spr_we | output | 1 | Sprite RAM write enable |
| spr_addr | output | 8 | Sprite RAM address |
| spr_wdata | output | 8 | Sprite RAM write data |
| spr_rdata | input | 8 | Sprite RAM read data (one-cycle latency) |

## Verification
The hardest case to reach is the boundary where the mode changes in the very cycle a processor write is presented. The outcome there depends only on the registered mode, so it cannot be seen from the result of a later read in the new mode alone. The stimulus raises the mode to pixel transfer together with a write, then drops it back to blank together with another write. It then reads both locations in a permitted mode, which shows that the first write landed and the second was dropped. Three-way contention on the sprite RAM is produced by raising DMA, a processor write and a processor read in adjacent cycles. After that, the sprite RAM is read back to prove that only the DMA byte was stored.

// File: rtl/vmg_pkg.sv
// Package: shared types and constants for the video memory access controller.
// Assumes: the display mode is a 2-bit code whose bit 1 marks the drawing phases.
package vmg_pkg;

    // Source of the data that the processor read path returns.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_PAT  = 2'd1,
        SRC_SPR  = 2'd2
    } rsrc_e;

    localparam logic [1:0] MODE_HBLANK = 2'b00;
    localparam logic [1:0] MODE_VBLANK = 2'b01;
    localparam logic [1:0] MODE_SEARCH = 2'b10;
    localparam logic [1:0] MODE_DRAW   = 2'b11;

endpackage

// File: rtl/vmg_addr_dec.sv
// Module: decodes a processor address into the pattern and sprite windows.
// Assumes: each window base is aligned to its own address width; the sprite
// window holds SPR_DEPTH bytes, and offsets at or past it fall outside.
module vmg_addr_dec #(
    parameter int          AW        = 16,
    parameter int          PAT_AW    = 13,
    parameter int          SPR_AW    = 8,
    parameter int unsigned SPR_DEPTH = 160,
    parameter logic [AW-1:0] PAT_BASE = 16'h8000,
    parameter logic [AW-1:0] SPR_BASE = 16'hFE00
) (
    input  logic [AW-1:0]     addr,
    output logic              hit_pat,
    output logic              hit_spr,
    output logic [PAT_AW-1:0] pat_off,
    output logic [SPR_AW-1:0] spr_off
);

    localparam logic [AW-1:0]   PAT_TAG = PAT_BASE >> PAT_AW;
    localparam logic [AW-1:0]   SPR_TAG = SPR_BASE >> SPR_AW;
    localparam logic [SPR_AW:0] SPR_LIM = (SPR_AW+1)'(SPR_DEPTH);

    // Window match and offset extraction.
    always_comb begin
        pat_off = addr[PAT_AW-1:0];
        spr_off = addr[SPR_AW-1:0];
        hit_pat = ((addr >> PAT_AW) == PAT_TAG);
        hit_spr = ((addr >> SPR_AW) == SPR_TAG) && ({1'b0, spr_off} < SPR_LIM);
    end

endmodule

// File: rtl/vmg_perm.sv
// Module: per-memory access permission from the registered display phase.
// Assumes: the mode and display flag are sampled every edge with no reset,
// so the decision in a cycle always reflects the previous edge's inputs.
module vmg_perm
    import vmg_pkg::*;
(
    input  logic       clk,
    input  logic [1:0] mode,
    input  logic       disp_on,
    input  logic       dma_active,
    output logic       pat_ok,
    output logic       spr_ok
);

    logic [1:0] mode_q;
    logic       on_q;

    // Hold the phase seen at the start of the current cycle.
    always_ff @(posedge clk) begin
        mode_q <= mode;
        on_q   <= disp_on;
    end

    // Pattern RAM closes only in transfer; sprite RAM closes in search and
    // transfer, and also whenever DMA owns it.
    always_comb begin
        pat_ok = !on_q || (mode_q != MODE_DRAW);
        spr_ok = (!on_q || !mode_q[1]) && !dma_active;
    end

endmodule

// File: rtl/vmg_spr_arb.sv
// Module: grants the single sprite RAM port to DMA, the fetcher or the processor.
// Assumes: the priority is DMA, then fetcher, then processor; RAM read latency
// is one cycle; a refused fetcher read returns all ones.
module vmg_spr_arb #(
    parameter int DW     = 8,
    parameter int SPR_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dma_active,
    input  logic [SPR_AW-1:0] dma_addr,
    input  logic [DW-1:0]     dma_wdata,
    input  logic              fetch_rd,
    input  logic [SPR_AW-1:0] fetch_addr,
    output logic [DW-1:0]     fetch_rdata,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              cpu_ok,
    input  logic [SPR_AW-1:0] cpu_off,
    input  logic [DW-1:0]     cpu_wdata,
    output logic              cpu_grant,
    output logic              spr_en,
    output logic              spr_we,
    output logic [SPR_AW-1:0] spr_addr,
    output logic [DW-1:0]     spr_wdata,
    input  logic [DW-1:0]     spr_rdata
);

    localparam logic [DW-1:0] OPEN_BUS = {DW{1'b1}};

    logic g_dma, g_fetch, g_cpu;
    logic fetch_ok_q;

    // Fixed-priority grant, all grants held low in reset.
    always_comb begin
        g_dma     = rst_n && dma_active;
        g_fetch   = rst_n && fetch_rd && !dma_active;
        g_cpu     = rst_n && cpu_req && cpu_ok && !dma_active && !fetch_rd;
        cpu_grant = g_cpu;
    end

    // Steer the winner onto the RAM port.
    always_comb begin
        spr_en    = g_dma || g_fetch || g_cpu;
        spr_we    = g_dma || (g_cpu && cpu_we);
        spr_addr  = cpu_off;
        spr_wdata = cpu_wdata;
        if (g_dma) begin
            spr_addr  = dma_addr;
            spr_wdata = dma_wdata;
        end else if (g_fetch) begin
            spr_addr  = fetch_addr;
            spr_wdata = '0;
        end
    end

    // Remember whether the fetcher's read was served, to align the 0xFF.
    always_ff @(posedge clk) begin
        if (!rst_n) fetch_ok_q <= 1'b0;
        else        fetch_ok_q <= g_fetch;
    end

    // Fetcher data: RAM output when served, all ones otherwise.
    always_comb begin
        fetch_rdata = fetch_ok_q ? spr_rdata : OPEN_BUS;
    end

    AST_SPR_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({g_dma, g_fetch, g_cpu})) else $error("sprite port shared"); // R10

    AST_DMA_OWNS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        dma_active |-> (spr_en && spr_we && spr_addr == dma_addr && spr_wdata == dma_wdata))
        else $error("DMA write not on port"); // R6

    AST_FETCH_LOST_FF: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dma_active && fetch_rd) |-> fetch_rdata == OPEN_BUS)
        else $error("fetcher saw data under DMA"); // R7

endmodule

// File: rtl/vmg_rd_align.sv
// Module: aligns the processor read data with the one-cycle RAM latency.
// Assumes: at most one RAM is read per cycle; refused or unmapped reads
// produce all ones in the cycle where data would have appeared.
module vmg_rd_align
    import vmg_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pat_rd,
    input  logic          spr_rd,
    input  logic [DW-1:0] pat_rdata,
    input  logic [DW-1:0] spr_rdata,
    output logic [DW-1:0] cpu_rdata
);

    localparam logic [DW-1:0] OPEN_BUS = {DW{1'b1}};

    rsrc_e src_q;

    // Record which RAM, if any, was read this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)      src_q <= SRC_NONE;
        else if (pat_rd) src_q <= SRC_PAT;
        else if (spr_rd) src_q <= SRC_SPR;
        else             src_q <= SRC_NONE;
    end

    // Select returned data.
    always_comb begin
        unique case (src_q)
            SRC_PAT: cpu_rdata = pat_rdata;
            SRC_SPR: cpu_rdata = spr_rdata;
            default: cpu_rdata = OPEN_BUS;
        endcase
    end

    AST_ONE_READ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        !(pat_rd && spr_rd)) else $error("two RAMs read at once"); // R8

endmodule

// File: rtl/vidmem_gate.sv
// Module: top of the display-mode gated video memory access controller.
// Assumes: external single-port synchronous RAMs with one-cycle read latency;
// one processor access per cycle; a write strobe wins over a read strobe.
module vidmem_gate
    import vmg_pkg::*;
#(
    parameter int          AW        = 16,
    parameter int          DW        = 8,
    parameter int          PAT_AW    = 13,
    parameter int          SPR_AW    = 8,
    parameter int unsigned SPR_DEPTH = 160,
    parameter logic [AW-1:0] PAT_BASE = 16'h8000,
    parameter logic [AW-1:0] SPR_BASE = 16'hFE00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     cpu_addr,
    input  logic [DW-1:0]     cpu_wdata,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    output logic [DW-1:0]     cpu_rdata,
    input  logic [1:0]        lcd_mode,
    input  logic              lcd_on,
    input  logic              dma_active,
    input  logic [SPR_AW-1:0] dma_addr,
    input  logic [DW-1:0]     dma_wdata,
    input  logic              fetch_rd,
    input  logic [SPR_AW-1:0] fetch_addr,
    output logic [DW-1:0]     fetch_rdata,
    output logic              pat_en,
    output logic              pat_we,
    output logic [PAT_AW-1:0] pat_addr,
    output logic [DW-1:0]     pat_wdata,
    input  logic [DW-1:0]     pat_rdata,
    output logic              spr_en,
    output logic              spr_we,
    output logic [SPR_AW-1:0] spr_addr,
    output logic [DW-1:0]     spr_wdata,
    input  logic [DW-1:0]     spr_rdata
);

    logic              hit_pat, hit_spr;
    logic [PAT_AW-1:0] pat_off;
    logic [SPR_AW-1:0] spr_off;
    logic              pat_ok, spr_ok;
    logic              cpu_req, g_pat, g_spr_cpu;

    vmg_addr_dec #(
        .AW(AW), .PAT_AW(PAT_AW), .SPR_AW(SPR_AW), .SPR_DEPTH(SPR_DEPTH),
        .PAT_BASE(PAT_BASE), .SPR_BASE(SPR_BASE)
    ) u_dec (
        .addr(cpu_addr), .hit_pat(hit_pat), .hit_spr(hit_spr),
        .pat_off(pat_off), .spr_off(spr_off)
    );

    vmg_perm u_perm (
        .clk(clk), .mode(lcd_mode), .disp_on(lcd_on), .dma_active(dma_active),
        .pat_ok(pat_ok), .spr_ok(spr_ok)
    );

    // Pattern RAM grant and port drive.
    always_comb begin
        cpu_req   = cpu_rd || cpu_wr;
        g_pat     = rst_n && cpu_req && hit_pat && pat_ok;
        pat_en    = g_pat;
        pat_we    = g_pat && cpu_wr;
        pat_addr  = pat_off;
        pat_wdata = cpu_wdata;
    end

    vmg_spr_arb #(.DW(DW), .SPR_AW(SPR_AW)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .dma_active(dma_active), .dma_addr(dma_addr), .dma_wdata(dma_wdata),
        .fetch_rd(fetch_rd), .fetch_addr(fetch_addr), .fetch_rdata(fetch_rdata),
        .cpu_req(cpu_req && hit_spr), .cpu_we(cpu_wr), .cpu_ok(spr_ok),
        .cpu_off(spr_off), .cpu_wdata(cpu_wdata), .cpu_grant(g_spr_cpu),
        .spr_en(spr_en), .spr_we(spr_we), .spr_addr(spr_addr),
        .spr_wdata(spr_wdata), .spr_rdata(spr_rdata)
    );

    vmg_rd_align #(.DW(DW)) u_align (
        .clk(clk), .rst_n(rst_n),
        .pat_rd(g_pat && !cpu_wr), .spr_rd(g_spr_cpu && !cpu_wr),
        .pat_rdata(pat_rdata), .spr_rdata(spr_rdata), .cpu_rdata(cpu_rdata)
    );

    AST_PAT_WE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        pat_we |-> !($past(lcd_mode) == MODE_DRAW && $past(lcd_on)))
        else $error("pattern write in transfer"); // R3

    AST_SPR_WE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (spr_we && !dma_active) |-> !($past(lcd_mode[1]) && $past(lcd_on)))
        else $error("sprite write while drawing"); // R2

    AST_PAT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pat_en && !pat_we) |-> cpu_rdata == pat_rdata)
        else $error("pattern read misaligned"); // R8

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |-> (!pat_en && !spr_en)) else $error("enable in reset"); // R9

endmodule

// File: tb/vidmem_gate_test.sv
module vidmem_gate_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [7:0]  cpu_rdata;
    logic [1:0]  lcd_mode = 2'b00;
    logic        lcd_on = 1'b1;
    logic        dma_active = 1'b0;
    logic [7:0]  dma_addr = '0, dma_wdata = '0;
    logic        fetch_rd = 1'b0;
    logic [7:0]  fetch_addr = '0;
    logic [7:0]  fetch_rdata;
    logic        pat_en, pat_we, spr_en, spr_we;
    logic [12:0] pat_addr;
    logic [7:0]  pat_wdata, pat_rdata, spr_addr, spr_wdata, spr_rdata;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    typedef struct {
        int       due;
        bit       fetch;
        logic [7:0] exp;
        string    tag;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    vidmem_gate uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
        .lcd_mode(lcd_mode), .lcd_on(lcd_on), .dma_active(dma_active),
        .dma_addr(dma_addr), .dma_wdata(dma_wdata), .fetch_rd(fetch_rd),
        .fetch_addr(fetch_addr), .fetch_rdata(fetch_rdata),
        .pat_en(pat_en), .pat_we(pat_we), .pat_addr(pat_addr),
        .pat_wdata(pat_wdata), .pat_rdata(pat_rdata),
        .spr_en(spr_en), .spr_we(spr_we), .spr_addr(spr_addr),
        .spr_wdata(spr_wdata), .spr_rdata(spr_rdata)
    );

    // External RAM models, one-cycle read latency.
    logic [7:0] pat_mem [8192];
    logic [7:0] spr_mem [256];
    initial begin
        for (int i = 0; i < 8192; i++) pat_mem[i] = 8'h00;
        for (int i = 0; i < 256; i++)  spr_mem[i] = 8'h00;
    end
    always @(posedge clk) begin
        if (pat_en) begin
            if (pat_we) pat_mem[pat_addr] <= pat_wdata;
            else        pat_rdata <= pat_mem[pat_addr];
        end
        if (spr_en) begin
            if (spr_we) spr_mem[spr_addr] <= spr_wdata;
            else        spr_rdata <= spr_mem[spr_addr];
        end
    end

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Monitor: compare results due in this cycle.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            item_t it;
            it = sb.pop_front();
            check(it.tag, it.fetch ? fetch_rdata : cpu_rdata, it.exp);
        end
    end

    task automatic clear();
        cpu_rd = 1'b0; cpu_wr = 1'b0; fetch_rd = 1'b0; dma_active = 1'b0;
    endtask

    task automatic set_mode(logic [1:0] m, logic on);
        @(negedge clk); clear(); lcd_mode = m; lcd_on = on;
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d);
        @(negedge clk); clear(); cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    endtask

    task automatic rd(logic [15:0] a, logic [7:0] exp, string tag);
        @(negedge clk); clear(); cpu_addr = a; cpu_rd = 1'b1;
        sb.push_back('{cyc + 1, 1'b0, exp, tag});
    endtask

    task automatic frd(logic [7:0] a, logic [7:0] exp, string tag);
        @(negedge clk); clear(); fetch_addr = a; fetch_rd = 1'b1;
        sb.push_back('{cyc + 1, 1'b1, exp, tag});
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R9: strobes active while in reset
        cpu_addr = 16'h8010; cpu_rd = 1'b1; fetch_rd = 1'b1;
        repeat (4) @(negedge clk);
        check("R9 cpu_rdata", cpu_rdata, 8'hFF);
        check("R9 fetch_rdata", fetch_rdata, 8'hFF);
        check("R9 enables", {6'd0, pat_en, spr_en}, 8'h00);
        clear();
        @(negedge clk); rst_n = 1'b1;

        // R1: blank modes
        set_mode(2'b00, 1'b1);
        wr(16'h8010, 8'hA5); wr(16'hFE05, 8'h3C);
        rd(16'h8010, 8'hA5, "R1 pat hblank");
        rd(16'hFE05, 8'h3C, "R1 spr hblank");
        set_mode(2'b01, 1'b1);
        wr(16'h9FFF, 8'h5A); wr(16'hFE9F, 8'hC3);
        rd(16'h9FFF, 8'h5A, "R1 pat vblank");
        rd(16'hFE9F, 8'hC3, "R1 spr vblank");

        // R2: search mode
        set_mode(2'b10, 1'b1);
        wr(16'h8020, 8'h11); wr(16'hFE05, 8'h77);
        rd(16'h8020, 8'h11, "R2 pat open");
        rd(16'hFE05, 8'hFF, "R2 spr read blocked");
        set_mode(2'b00, 1'b1);
        rd(16'hFE05, 8'h3C, "R2 spr write dropped");

        // R3: transfer mode
        set_mode(2'b11, 1'b1);
        wr(16'h8010, 8'hEE); wr(16'hFE9F, 8'h01);
        rd(16'h8010, 8'hFF, "R3 pat read blocked");
        rd(16'hFE9F, 8'hFF, "R3 spr read blocked");
        set_mode(2'b00, 1'b1);
        rd(16'h8010, 8'hA5, "R3 pat write dropped");
        rd(16'hFE9F, 8'hC3, "R3 spr write dropped");

        // R4: display off, mode bits say transfer
        set_mode(2'b11, 1'b0);
        wr(16'h8030, 8'h99); wr(16'hFE10, 8'h88);
        rd(16'h8030, 8'h99, "R4 pat off");
        rd(16'hFE10, 8'h88, "R4 spr off");

        // R5: mode change together with the access
        set_mode(2'b00, 1'b1);
        @(negedge clk); clear(); lcd_mode = 2'b11;
        cpu_addr = 16'h8040; cpu_wdata = 8'h42; cpu_wr = 1'b1;
        rd(16'h8040, 8'hFF, "R5 new mode applies next");
        @(negedge clk); clear(); lcd_mode = 2'b00;
        cpu_addr = 16'h8050; cpu_wdata = 8'h24; cpu_wr = 1'b1;
        rd(16'h8040, 8'h42, "R5 write under old blank");
        rd(16'h8050, 8'h00, "R5 write under old transfer");

        // R6: DMA owns sprite RAM
        @(negedge clk); clear(); dma_active = 1'b1; dma_addr = 8'h20; dma_wdata = 8'h5D;
        cpu_addr = 16'hFE20; cpu_wdata = 8'h11; cpu_wr = 1'b1;
        @(negedge clk); clear(); dma_active = 1'b1; dma_addr = 8'h21; dma_wdata = 8'h6E;
        cpu_addr = 16'hFE05; cpu_rd = 1'b1;
        sb.push_back('{cyc + 1, 1'b0, 8'hFF, "R6 cpu read under DMA"});
        rd(16'hFE20, 8'h5D, "R6 DMA byte kept");
        rd(16'hFE21, 8'h6E, "R6 DMA second byte");

        // R7: fetcher with and without DMA
        set_mode(2'b11, 1'b1);
        frd(8'h05, 8'h3C, "R7 fetch served");
        @(negedge clk); clear(); dma_active = 1'b1; dma_addr = 8'h30; dma_wdata = 8'h06;
        fetch_addr = 8'h05; fetch_rd = 1'b1;
        sb.push_back('{cyc + 1, 1'b1, 8'hFF, "R7 fetch under DMA"});

        // R10: fetcher beats processor
        set_mode(2'b00, 1'b1);
        @(negedge clk); clear(); fetch_addr = 8'h9F; fetch_rd = 1'b1;
        cpu_addr = 16'hFE05; cpu_rd = 1'b1;
        sb.push_back('{cyc + 1, 1'b1, 8'hC3, "R10 fetch wins"});
        sb.push_back('{cyc + 1, 1'b0, 8'hFF, "R10 cpu loses"});

        // R8: unmapped addresses
        wr(16'hFEA0, 8'h12);
        rd(16'hFEA0, 8'hFF, "R8 past sprite window");
        rd(16'h7FFF, 8'hFF, "R8 below pattern window");
        rd(16'hC000, 8'hFF, "R8 work area");
        rd(16'h8030, 8'h99, "R8 latency after unmapped");

        @(negedge clk); clear();
        repeat (3) @(negedge clk);
        check("R8 scoreboard drained", 8'(sb.size()), 8'h00);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule